// File: doc/BRIEF.md
# Block-Stride Page Transfer Engine

This engine moves one strided set of data blocks between an on-chip scratchpad and off-chip memory in response to a single command. A page-load command gathers blocks from off-chip memory into the scratchpad. A page-store command scatters scratchpad data back out to off-chip memory. A command carries five values: the off-chip base word address, the scratchpad base word address, a block length in 32-bit words, a stride between block starts, and a block count. On the off-chip side, block k begins at base + k*stride. On the scratchpad side the blocks are packed one after another. Words that fall in the gaps between blocks never cross the bus, so a transfer fetches only the elements that are wanted.

The engine sends one burst request per block on a request channel. It sends these requests back to back, without waiting for data, so the memory's fixed startup latency is paid once per command and not once per block. Read data arrives on a 4-byte beat channel and goes straight into the scratchpad. Store data is read from the scratchpad through a two-entry staging buffer and driven onto a 4-byte write beat channel.

The request, write-beat and read-beat channels are valid/ready. A producer that raises valid must keep it high, with its payload unchanged, until the cycle in which ready is also high. The read-beat ready is held high for the whole of a page-load, so the scratchpad never stalls the memory. The command, busy, done and error pins are plain level or pulse signals. The scratchpad port is a simple single-port RAM interface with a one-cycle read latency.

Top module: `bstride_xfer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, err, mreq_valid, mwd_valid, mrd_ready and spm_en are all low.
- R2: After a page-load (cmd_store=0) with length L and count C, for every i < L*C the scratchpad word (spm_base + i) mod 2^SAW holds off-chip word (ext_base + (i/L)*stride + i mod L) mod 2^AW. No other scratchpad word changes.
- R3: After a page-store (cmd_store=1), for every i < L*C the off-chip word (ext_base + (i/L)*stride + i mod L) mod 2^AW holds the scratchpad word (spm_base + i) mod 2^SAW. Blocks are written in increasing k, and off-chip words in the gaps between blocks are unchanged.
- R4: A command with non-zero L and C produces exactly C burst requests. Request k has address (ext_base + k*stride) mod 2^AW, mreq_len = L, and mreq_write equal to cmd_store.
- R5: All burst requests of a command are issued without waiting for read data. When the memory accepts every request at once and C is below its latency, all C requests are accepted before the first read beat returns.
- R6: A command with L = 0 or C = 0 raises done in the cycle after cmd_valid. busy stays low and no request or beat channel goes active.
- R7: A cmd_valid pulse while busy is high is ignored: the running transfer completes unchanged. err goes high in the next cycle and stays high until reset.
- R8: done is high for exactly one cycle, namely the cycle after the final data beat's handshake. busy is low in that cycle and falls only together with done.
- R9: mreq_valid and mwd_valid, once high without ready, stay high with address, length, direction and data stable in the next cycle. mrd_ready is high only while a page-load is running.
- R10: Off-chip addresses wrap modulo 2^AW and scratchpad addresses wrap modulo 2^SAW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_store | input | 1 | 0 = page-load, 1 = page-store |
| cmd_ext_base | input | AW | Off-chip base word address |
| cmd_spm_base | input | SAW | Scratchpad base word address |
| cmd_blk_len | input | LW | Words per block |
| cmd_stride | input | AW | Word distance between block starts |
| cmd_blk_cnt | input | CW | Number of blocks |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky: a command arrived while busy |
| mreq_valid | output | 1 | Burst request valid |
| mreq_ready | input | 1 | Burst request accepted |
| mreq_write | output | 1 | Burst direction, 1 = write |
| mreq_addr | output | AW | Burst start word address |
| mreq_len | output | LW | Burst length in beats |
| mwd_valid | output | 1 | Write beat valid |
| mwd_ready | input | 1 | Write beat accepted |
| mwd_data | output | 32 | Write beat data |
| mrd_valid | input | 1 | Read beat valid |
| mrd_ready | output | 1 | Read beat accepted |
| mrd_data | input | 32 | Read beat data |
| spm_en | output | 1 | Scratchpad access enable |
| spm_we | output | 1 | Scratchpad write enable |
| spm_addr | output | SAW | Scratchpad word address |
| spm_wdata | output | 32 | Scratchpad write data |
| spm_rdata | input | 32 | Scratchpad read data, one cycle after a read |

## Verification
The bench builds the engine with AW=11, SAW=8, LW=4 and CW=4. The largest command then moves 225 words, which fits in the 256-word scratchpad model without overlapping itself. A random base and stride easily run past the top of the 2048-word off-chip model, so wrapping on both address spaces is exercised. A 15-block command fits below the 40-cycle memory latency, which makes the requests-ahead-of-data property observable at the ports. Random stalls on all three memory channels exercise the back-pressure rules, and strides smaller than the block length exercise overlapping blocks.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
  localparam int unsigned BEAT_W      = 32;
  localparam int unsigned STAGE_DEPTH = 2;

  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/bsx_req_gen.sv
// Issues one burst request per block, walking the off-chip address by the stride.
module bsx_req_gen
  import bsx_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [LW-1:0] len,
  input  logic [CW-1:0] cnt,
  input  xfer_dir_e     dir,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [LW-1:0] req_len,
  output logic          req_write
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] stride_q;
  logic [LW-1:0] len_q;
  logic [CW-1:0] left_q;
  xfer_dir_e     dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      left_q   <= '0;
      dir_q    <= DIR_LOAD;
    end else if (start) begin
      addr_q   <= base;
      stride_q <= stride;
      len_q    <= len;
      left_q   <= cnt;
      dir_q    <= dir;
    end else if (req_valid && req_ready) begin
      addr_q <= addr_q + stride_q;
      left_q <= left_q - CW'(1);
    end
  end

  assign req_valid = (left_q != '0);
  assign req_addr  = addr_q;
  assign req_len   = len_q;
  assign req_write = (dir_q == DIR_STORE);
endmodule

// File: rtl/bsx_mover.sv
// Moves data beats between the memory beat channels and the scratchpad.
module bsx_mover
  import bsx_pkg::*;
#(
  parameter int unsigned SAW = 12,
  parameter int unsigned TW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_dir_e         dir,
  input  logic [SAW-1:0]    spm_base,
  input  logic [TW-1:0]     total,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [BEAT_W-1:0] rd_data,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [BEAT_W-1:0] wd_data,
  output logic              spm_en,
  output logic              spm_we,
  output logic [SAW-1:0]    spm_addr,
  output logic [BEAT_W-1:0] spm_wdata,
  input  logic [BEAT_W-1:0] spm_rdata,
  output logic              last
);
  localparam int unsigned FILL_W = $clog2(STAGE_DEPTH + 1);
  localparam int unsigned OCC_W  = FILL_W + 1;

  logic              active_q;
  xfer_dir_e         dir_q;
  logic [TW-1:0]     left_q;
  logic [TW-1:0]     rd_left_q;
  logic [SAW-1:0]    wptr_q;
  logic [SAW-1:0]    rptr_q;
  logic [BEAT_W-1:0] stage_q [STAGE_DEPTH];
  logic              head_q;
  logic [FILL_W-1:0] fill_q;
  logic              pend_q;

  logic              load_mode;
  logic              store_mode;
  logic              rd_hs;
  logic              wd_hs;
  logic              beat;
  logic              issue;
  logic [OCC_W-1:0]  occ;
  logic              push_idx;

  assign load_mode  = active_q && (dir_q == DIR_LOAD);
  assign store_mode = active_q && (dir_q == DIR_STORE);

  assign rd_ready = load_mode;
  assign rd_hs    = rd_valid && load_mode;
  assign wd_valid = store_mode && (fill_q != '0);
  assign wd_hs    = wd_valid && wd_ready;
  assign wd_data  = stage_q[head_q];
  assign beat     = rd_hs || wd_hs;
  assign last     = beat && (left_q == TW'(1));

  // Staging occupancy counts words held plus a read still in flight.
  assign occ   = OCC_W'(fill_q) + OCC_W'(pend_q);
  assign issue = store_mode && (rd_left_q != '0) &&
                 ((occ < OCC_W'(STAGE_DEPTH)) || ((occ == OCC_W'(STAGE_DEPTH)) && wd_hs));
  assign push_idx = head_q ^ fill_q[0];

  assign spm_en    = rd_hs || issue;
  assign spm_we    = rd_hs;
  assign spm_addr  = rd_hs ? wptr_q : rptr_q;
  assign spm_wdata = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      dir_q     <= DIR_LOAD;
      left_q    <= '0;
      rd_left_q <= '0;
      wptr_q    <= '0;
      rptr_q    <= '0;
      head_q    <= 1'b0;
      fill_q    <= '0;
      pend_q    <= 1'b0;
    end else if (start) begin
      active_q  <= 1'b1;
      dir_q     <= dir;
      left_q    <= total;
      rd_left_q <= total;
      wptr_q    <= spm_base;
      rptr_q    <= spm_base;
      head_q    <= 1'b0;
      fill_q    <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (last) active_q <= 1'b0;
      if (beat) left_q <= left_q - TW'(1);
      if (rd_hs) wptr_q <= wptr_q + SAW'(1);
      if (issue) begin
        rptr_q    <= rptr_q + SAW'(1);
        rd_left_q <= rd_left_q - TW'(1);
      end
      pend_q <= issue;
      if (wd_hs) head_q <= ~head_q;
      fill_q <= fill_q + FILL_W'(pend_q) - FILL_W'(wd_hs);
    end
  end

  generate
    for (genvar g = 0; g < STAGE_DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else if (pend_q && (push_idx == 1'(g))) begin
          stage_q[g] <= spm_rdata;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bstride_xfer.sv
// Block-stride page transfer engine: command control and submodule wiring.
module bstride_xfer
  import bsx_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned SAW = 12,
  parameter int unsigned LW  = 8,
  parameter int unsigned CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic           cmd_store,
  input  logic [AW-1:0]  cmd_ext_base,
  input  logic [SAW-1:0] cmd_spm_base,
  input  logic [LW-1:0]  cmd_blk_len,
  input  logic [AW-1:0]  cmd_stride,
  input  logic [CW-1:0]  cmd_blk_cnt,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           mreq_valid,
  input  logic           mreq_ready,
  output logic           mreq_write,
  output logic [AW-1:0]  mreq_addr,
  output logic [LW-1:0]  mreq_len,
  output logic           mwd_valid,
  input  logic           mwd_ready,
  output logic [31:0]    mwd_data,
  input  logic           mrd_valid,
  output logic           mrd_ready,
  input  logic [31:0]    mrd_data,
  output logic           spm_en,
  output logic           spm_we,
  output logic [SAW-1:0] spm_addr,
  output logic [31:0]    spm_wdata,
  input  logic [31:0]    spm_rdata
);
  localparam int unsigned TW = LW + CW;

  logic          busy_q;
  logic          done_q;
  logic          err_q;
  logic [TW-1:0] total;
  logic          accept;
  logic          empty_cmd;
  logic          launch;
  logic          reject;
  logic          last_beat;
  xfer_dir_e     dir;

  assign dir       = xfer_dir_e'(cmd_store);
  assign total     = TW'(cmd_blk_len) * TW'(cmd_blk_cnt);
  assign accept    = cmd_valid && !busy_q;
  assign empty_cmd = (total == '0);
  assign launch    = accept && !empty_cmd;
  assign reject    = cmd_valid && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (launch) busy_q <= 1'b1;
      else if (last_beat) busy_q <= 1'b0;
      done_q <= (accept && empty_cmd) || last_beat;
      if (reject) err_q <= 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  bsx_req_gen #(
    .AW(AW),
    .LW(LW),
    .CW(CW)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .base     (cmd_ext_base),
    .stride   (cmd_stride),
    .len      (cmd_blk_len),
    .cnt      (cmd_blk_cnt),
    .dir      (dir),
    .req_valid(mreq_valid),
    .req_ready(mreq_ready),
    .req_addr (mreq_addr),
    .req_len  (mreq_len),
    .req_write(mreq_write)
  );

  bsx_mover #(
    .SAW(SAW),
    .TW (TW)
  ) u_mover (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .dir      (dir),
    .spm_base (cmd_spm_base),
    .total    (total),
    .rd_valid (mrd_valid),
    .rd_ready (mrd_ready),
    .rd_data  (mrd_data),
    .wd_valid (mwd_valid),
    .wd_ready (mwd_ready),
    .wd_data  (mwd_data),
    .spm_en   (spm_en),
    .spm_we   (spm_we),
    .spm_addr (spm_addr),
    .spm_wdata(spm_wdata),
    .spm_rdata(spm_rdata),
    .last     (last_beat)
  );
endmodule

// File: rtl/bstride_xfer_chk.sv
module bstride_xfer_chk #(
  parameter int unsigned AW  = 16,
  parameter int unsigned SAW = 12,
  parameter int unsigned LW  = 8,
  parameter int unsigned CW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic          mreq_write,
  input logic [AW-1:0] mreq_addr,
  input logic [LW-1:0] mreq_len,
  input logic          mwd_valid,
  input logic          mwd_ready,
  input logic [31:0]   mwd_data,
  input logic          mrd_valid,
  input logic          mrd_ready,
  input logic          spm_en,
  input logic          spm_we
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) &&
    $stable(mreq_len) && $stable(mreq_write));

  // R9
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mwd_valid && !mwd_ready |=> mwd_valid && $stable(mwd_data));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mreq_valid && !mwd_valid && !mrd_ready);

  // R2
  spm_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spm_we |-> spm_en && mrd_valid && mrd_ready);
endmodule

bind bstride_xfer bstride_xfer_chk #(
  .AW (AW),
  .SAW(SAW),
  .LW (LW),
  .CW (CW)
) u_chk (.*);

// File: tb/bstride_xfer_test.sv
`timescale 1ns/1ps
module bstride_xfer_test;
  localparam int AW = 11, SAW = 8, LW = 4, CW = 4;
  localparam int EXT_N = 1 << AW, SPM_N = 1 << SAW, LAT = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_store = 1'b0;
  logic [AW-1:0] cmd_ext_base = '0, cmd_stride = '0;
  logic [SAW-1:0] cmd_spm_base = '0;
  logic [LW-1:0] cmd_blk_len = '0;
  logic [CW-1:0] cmd_blk_cnt = '0;
  logic busy, done, err;
  logic mreq_valid, mreq_ready, mreq_write;
  logic [AW-1:0] mreq_addr;
  logic [LW-1:0] mreq_len;
  logic mwd_valid, mwd_ready, mrd_valid, mrd_ready;
  logic [31:0] mwd_data, mrd_data;
  logic spm_en, spm_we;
  logic [SAW-1:0] spm_addr;
  logic [31:0] spm_wdata, spm_rdata;

  always #4 clk = ~clk;

  bstride_xfer #(.AW(AW), .SAW(SAW), .LW(LW), .CW(CW)) uut (.*);

  int checks = 0, failures = 0;
  logic [31:0] ext_mem [EXT_N];
  logic [31:0] spm_mem [SPM_N];
  logic [31:0] ext_exp [EXT_N];
  logic [31:0] spm_exp [SPM_N];

  // Off-chip memory model: in-order request queue, fixed first-data latency.
  int q_addr [16], q_len [16], q_t [16];
  bit q_wr [16];
  int q_rp = 0, q_wp = 0, q_n = 0, cur_beat = 0, cyc = 0;
  int lg_addr [1024], lg_len [1024];
  bit lg_wr [1024];
  int log_n = 0, rd_total = 0, rd_mark = -1, req_snap = 0;
  logic gr_req = 1'b1, gr_rd = 1'b1, gr_wd = 1'b1;
  bit stall = 1'b0;

  wire push  = mreq_valid && mreq_ready;
  wire rbeat = mrd_valid && mrd_ready;
  wire wbeat = mwd_valid && mwd_ready;
  wire pop   = (rbeat || wbeat) && (cur_beat == q_len[q_rp] - 1);

  assign mreq_ready = gr_req && (q_n < 16);
  assign mrd_valid  = (q_n != 0) && !q_wr[q_rp] && (cyc >= q_t[q_rp] + LAT) && gr_rd;
  assign mrd_data   = ext_mem[(q_addr[q_rp] + cur_beat) % EXT_N];
  assign mwd_ready  = (q_n != 0) && q_wr[q_rp] && gr_wd;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    gr_req <= stall ? ($urandom_range(0, 3) != 0) : 1'b1;
    gr_rd  <= stall ? ($urandom_range(0, 3) != 0) : 1'b1;
    gr_wd  <= stall ? ($urandom_range(0, 3) != 0) : 1'b1;
    if (push) begin
      q_addr[q_wp] <= int'(mreq_addr);
      q_len[q_wp]  <= int'(mreq_len);
      q_wr[q_wp]   <= mreq_write;
      q_t[q_wp]    <= cyc;
      q_wp         <= (q_wp + 1) % 16;
      lg_addr[log_n % 1024] <= int'(mreq_addr);
      lg_len[log_n % 1024]  <= int'(mreq_len);
      lg_wr[log_n % 1024]   <= mreq_write;
      log_n <= log_n + 1;
    end
    if (rbeat) begin
      if (rd_total == rd_mark) req_snap <= log_n;
      rd_total <= rd_total + 1;
    end
    if (wbeat) ext_mem[(q_addr[q_rp] + cur_beat) % EXT_N] <= mwd_data;
    if (rbeat || wbeat) begin
      if (pop) begin
        cur_beat <= 0;
        q_rp     <= (q_rp + 1) % 16;
      end else begin
        cur_beat <= cur_beat + 1;
      end
    end
    q_n <= q_n + int'(push) - int'(pop);
  end

  // Scratchpad model, one-cycle read latency.
  always @(posedge clk) begin
    if (spm_en) begin
      if (spm_we) spm_mem[spm_addr] <= spm_wdata;
      else spm_rdata <= spm_mem[spm_addr];
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int log_base;
  task automatic start_cmd(bit st, int eb, int sb, int ln, int sd, int ct);
    @(negedge clk);
    for (int i = 0; i < EXT_N; i++) ext_exp[i] = ext_mem[i];
    for (int i = 0; i < SPM_N; i++) spm_exp[i] = spm_mem[i];
    log_base = log_n;
    rd_mark = rd_total;
    cmd_store = st; cmd_ext_base = AW'(eb); cmd_spm_base = SAW'(sb);
    cmd_blk_len = LW'(ln); cmd_stride = AW'(sd); cmd_blk_cnt = CW'(ct);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, req, "completion timeout", n, 0);
    chk(busy === 1'b0, "R8", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R8", "done one-cycle pulse", done, 0);
  endtask

  // Expected results computed from R2/R3/R4/R10 formulas.
  task automatic verify(bit st, int eb, int sb, int ln, int sd, int ct);
    int bad = -1;
    for (int i = 0; i < ln * ct; i++) begin
      int ea = (eb + (i / ln) * sd + (i % ln)) % EXT_N;
      int sa = (sb + i) % SPM_N;
      if (st) ext_exp[ea] = spm_exp[sa];
      else spm_exp[sa] = ext_exp[ea];
    end
    if (st) begin
      for (int i = 0; i < EXT_N; i++) if (bad < 0 && ext_mem[i] !== ext_exp[i]) bad = i;
      chk(bad < 0, "R3", "store off-chip contents", bad < 0 ? 0 : ext_mem[bad],
          bad < 0 ? 0 : ext_exp[bad]);
    end else begin
      for (int i = 0; i < SPM_N; i++) if (bad < 0 && spm_mem[i] !== spm_exp[i]) bad = i;
      chk(bad < 0, "R2", "load scratchpad contents", bad < 0 ? 0 : spm_mem[bad],
          bad < 0 ? 0 : spm_exp[bad]);
    end
    chk(log_n - log_base == ct, "R4", "request count", log_n - log_base, ct);
    bad = -1;
    for (int k = 0; k < ct && k < log_n - log_base; k++) begin
      int j = (log_base + k) % 1024;
      if (bad < 0 && (lg_addr[j] != (eb + k * sd) % EXT_N || lg_len[j] != ln || lg_wr[j] != st))
        bad = k;
    end
    chk(bad < 0, "R4", "request address/length/direction", bad < 0 ? 0 : lg_addr[(log_base + bad) % 1024],
        bad < 0 ? 0 : (eb + bad * sd) % EXT_N);
  endtask

  task automatic run(bit st, int eb, int sb, int ln, int sd, int ct);
    start_cmd(st, eb, sb, ln, sd, ct);
    wait_done(st ? "R3" : "R2");
    verify(st, eb, sb, ln, sd, ct);
  endtask

  initial begin
    void'($urandom(32'd20417));
    for (int i = 0; i < EXT_N; i++) ext_mem[i] = $urandom;
    for (int i = 0; i < SPM_N; i++) spm_mem[i] = $urandom;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 0 && done === 0 && err === 0, "R1", "status in reset", {busy, done, err}, 0);
    chk(mreq_valid === 0 && mwd_valid === 0 && mrd_ready === 0 && spm_en === 0, "R1",
        "channels idle in reset", {mreq_valid, mwd_valid, mrd_ready, spm_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0 && mreq_valid === 0, "R1", "idle after reset",
        {busy, done, err, mreq_valid}, 0);

    // R6: zero count and zero length
    start_cmd(1'b0, 5, 0, 4, 3, 0);
    chk(done === 1 && busy === 0, "R6", "zero count done at once", {done, busy}, 2'b10);
    @(negedge clk);
    chk(done === 0 && log_n == log_base, "R6", "zero count no bus activity", log_n - log_base, 0);
    start_cmd(1'b1, 5, 0, 0, 3, 7);
    chk(done === 1 && busy === 0, "R6", "zero length done at once", {done, busy}, 2'b10);
    @(negedge clk);
    chk(done === 0 && log_n == log_base && ext_mem[5] === ext_exp[5], "R6",
        "zero length no bus activity", log_n - log_base, 0);

    // R5: all requests before first read data
    run(1'b0, 100, 10, 2, 9, 8);
    chk(req_snap == log_base + 8, "R5", "requests issued before first data", req_snap - log_base, 8);
    run(1'b0, 300, 40, 1, 3, 15);
    chk(req_snap == log_base + 15, "R5", "15 requests ahead of data", req_snap - log_base, 15);

    // R10: wrap on both address spaces
    run(1'b0, EXT_N - 8, SPM_N - 5, 4, 5, 6);
    run(1'b1, EXT_N - 3, SPM_N - 2, 3, 7, 5);

    // R3: gaps untouched, and overlapping blocks with stride below length
    run(1'b1, 500, 20, 4, 10, 6);
    run(1'b1, 700, 60, 5, 2, 4);

    // R7: command while busy is ignored and err sticks
    chk(err === 0, "R7", "err clear before reject", err, 0);
    start_cmd(1'b0, 900, 100, 15, 20, 10);
    repeat (20) @(negedge clk);
    cmd_store = 1'b1; cmd_ext_base = 11'd3; cmd_blk_cnt = 4'd3; cmd_blk_len = 4'd2;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err === 1, "R7", "err after rejected command", err, 1);
    wait_done("R7");
    verify(1'b0, 900, 100, 15, 20, 10);

    // Random mix under back-pressure (R2, R3, R4, R9)
    for (int t = 0; t < 30; t++) begin
      bit st = 1'($urandom % 2);
      int ln = 1 + $urandom % 15, ct = 1 + $urandom % 15;
      int sd = $urandom % 300, eb = $urandom % EXT_N, sb = $urandom % SPM_N;
      stall = 1'($urandom % 2);
      run(st, eb, sb, ln, sd, ct);
    end
    stall = 1'b0;
    chk(err === 1, "R7", "err still sticky", err, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule